// File: doc/BRIEF.md
# Per-Interrupt Distributor State Array

This block is the storage core of a multi-processor interrupt distributor. For every interrupt it keeps five per-CPU bit masks: enable, latched pending, active, sampled line level and group. It also keeps two single bits per interrupt, trigger mode and handling model, plus a priority store. The number of interrupts, the number of CPUs, the count of per-CPU (banked) interrupts and the priority width are all parameters.

Software changes the state through a one-cycle write strobe. The strobe carries an operation code, an interrupt number, a CPU mask and a data word. Combinational read ports return every stored field for one interrupt, together with the pending status and priority for one interrupt/CPU pair.

Raw interrupt lines come in per interrupt and per CPU. Acknowledge and deactivate commands, each naming one interrupt and one CPU, move the pending and active bits. Arbitration between interrupts, the CPU-side interface and bus decoding live outside this block.

Top module: `irq_state_array`

## Requirements
- R1: After reset, every interrupt is in this state: enable, latched pending, active and group masks all zero; trigger mode level (0); model bit zero; every priority copy zero.
- R2: A write with op 0/1 sets/clears enable, op 2/3 sets/clears latched pending, op 4/5 sets/clears active, and op 6/7 sets/clears group. Only the CPU bits selected by the mask change. Read-back is combinational and shows the result the cycle after the write.
- R3: Write op codes 11 to 15 change no stored field of the addressed interrupt.
- R4: In the normal mode, a level-triggered interrupt is reported pending for a CPU while that CPU's line, sampled one clock earlier, is high. A level-triggered line does not set the latched pending bit.
- R5: A pending bit set by software keeps the interrupt pending. If the latched bit is cleared while a level-triggered line is still high, the interrupt stays pending until the line falls.
- R6: Write op 8 with data bit 0 equal to 1 selects edge trigger, and 0 selects level trigger. For an edge-triggered interrupt, a rising line for a CPU latches that CPU's pending bit. The bit stays set after the line falls, and a high line adds no pending term of its own.
- R7: With the legacy parameter set, pending status is the latched bit alone. A rising line latches pending in either trigger mode, and a falling line does not remove it.
- R8: An acknowledge for an interrupt whose model bit is 0 clears the pending bit of the acknowledging CPU only, and sets that CPU's active bit.
- R9: Write op 9 loads the model bit from data bit 0. An acknowledge for an interrupt whose model bit is 1 clears the pending bits of all CPUs.
- R10: A deactivate clears the active bit of the named CPU only.
- R11: Write op 10 stores a priority. For an interrupt below the banked count, each CPU selected by the mask gets its own copy written. Above that count, one shared value is written that every CPU reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_line_i | input | NUM_IRQ*NUM_CPU | Raw lines, bit irq*NUM_CPU+cpu |
| sw_wr_i | input | 1 | Software write strobe |
| sw_op_i | input | 4 | Write operation code |
| sw_irq_i | input | log2(NUM_IRQ) | Interrupt addressed by the write |
| sw_cpu_mask_i | input | NUM_CPU | CPU selection mask |
| sw_data_i | input | PRIO_W | Priority value or bit 0 for mode writes |
| rd_irq_i | input | log2(NUM_IRQ) | Interrupt whose fields are read |
| rd_enable_o | output | NUM_CPU | Enable mask |
| rd_pend_o | output | NUM_CPU | Latched pending mask |
| rd_active_o | output | NUM_CPU | Active mask |
| rd_level_o | output | NUM_CPU | Sampled line levels |
| rd_group_o | output | NUM_CPU | Group mask |
| rd_edge_o | output | 1 | Trigger mode, 1 = edge |
| rd_model_o | output | 1 | Handling model bit |
| q_irq_i | input | log2(NUM_IRQ) | Interrupt for pending/priority query |
| q_cpu_i | input | log2(NUM_CPU) | CPU for the query |
| q_pending_o | output | 1 | Pending status for the pair |
| q_prio_o | output | PRIO_W | Priority for the pair |
| ack_i | input | 1 | Acknowledge command |
| deact_i | input | 1 | Deactivate command |
| cmd_irq_i | input | log2(NUM_IRQ) | Interrupt named by the command |
| cmd_cpu_i | input | log2(NUM_CPU) | CPU named by the command |

## Verification
The bench builds two copies side by side, both with eight interrupts, two CPUs, four banked interrupts and 4-bit priorities. One copy runs in the normal mode and the other in the legacy mode. With so small a space, every set/clear field can be swept over every interrupt and every CPU mask, and the priority store can be filled for every interrupt and CPU. Running both modes on the same line waveforms exposes where live-level and latched-only pending status part ways.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

    // Software write operations; codes 11..15 are reserved and inert
    typedef enum logic [3:0] {
        OP_EN_SET   = 4'd0,
        OP_EN_CLR   = 4'd1,
        OP_PEND_SET = 4'd2,
        OP_PEND_CLR = 4'd3,
        OP_ACT_SET  = 4'd4,
        OP_ACT_CLR  = 4'd5,
        OP_GRP_SET  = 4'd6,
        OP_GRP_CLR  = 4'd7,
        OP_TRIG     = 4'd8,
        OP_MODEL    = 4'd9,
        OP_PRIO     = 4'd10
    } sw_op_e;

endpackage

// File: rtl/irq_slot.sv
module irq_slot
    import irqs_pkg::*;
#(
    parameter int NCPU   = 8,
    parameter bit LEGACY = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCPU-1:0] line_i,
    input  logic            wr_hit_i,
    input  sw_op_e          wr_op_i,
    input  logic [NCPU-1:0] wr_mask_i,
    input  logic            wr_bit_i,
    input  logic            ack_i,
    input  logic            deact_i,
    input  logic [NCPU-1:0] cpu_sel_i,
    output logic [NCPU-1:0] en_o,
    output logic [NCPU-1:0] pend_o,
    output logic [NCPU-1:0] act_o,
    output logic [NCPU-1:0] lvl_o,
    output logic [NCPU-1:0] grp_o,
    output logic [NCPU-1:0] status_o,
    output logic            edge_o,
    output logic            model_o
);

    typedef struct packed {
        logic [NCPU-1:0] en;
        logic [NCPU-1:0] pend;
        logic [NCPU-1:0] act;
        logic [NCPU-1:0] lvl;
        logic [NCPU-1:0] grp;
        logic            edge_trig;
        logic            model;
    } slot_t;

    slot_t           slot_d, slot_q;
    logic [NCPU-1:0] rise;

    always_comb begin
        slot_d     = slot_q;
        rise       = line_i & ~slot_q.lvl;
        slot_d.lvl = line_i;
        // line edges latch pending first; software and commands follow
        if (LEGACY || slot_q.edge_trig) begin
            slot_d.pend = slot_d.pend | rise;
        end
        if (wr_hit_i) begin
            case (wr_op_i)
                OP_EN_SET:   slot_d.en        = slot_d.en | wr_mask_i;
                OP_EN_CLR:   slot_d.en        = slot_d.en & ~wr_mask_i;
                OP_PEND_SET: slot_d.pend      = slot_d.pend | wr_mask_i;
                OP_PEND_CLR: slot_d.pend      = slot_d.pend & ~wr_mask_i;
                OP_ACT_SET:  slot_d.act       = slot_d.act | wr_mask_i;
                OP_ACT_CLR:  slot_d.act       = slot_d.act & ~wr_mask_i;
                OP_GRP_SET:  slot_d.grp       = slot_d.grp | wr_mask_i;
                OP_GRP_CLR:  slot_d.grp       = slot_d.grp & ~wr_mask_i;
                OP_TRIG:     slot_d.edge_trig = wr_bit_i;
                OP_MODEL:    slot_d.model     = wr_bit_i;
                default:     ;
            endcase
        end
        if (ack_i) begin
            if (slot_q.model) begin
                slot_d.pend = '0;
            end else begin
                slot_d.pend = slot_d.pend & ~cpu_sel_i;
            end
            slot_d.act = slot_d.act | cpu_sel_i;
        end
        if (deact_i) begin
            slot_d.act = slot_d.act & ~cpu_sel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign en_o    = slot_q.en;
    assign pend_o  = slot_q.pend;
    assign act_o   = slot_q.act;
    assign lvl_o   = slot_q.lvl;
    assign grp_o   = slot_q.grp;
    assign edge_o  = slot_q.edge_trig;
    assign model_o = slot_q.model;

    if (LEGACY) begin : g_status_legacy
        assign status_o = slot_q.pend;
    end else begin : g_status_live
        assign status_o = slot_q.pend | (slot_q.edge_trig ? '0 : slot_q.lvl);
    end

    // R8
    ack_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i && !deact_i && !wr_hit_i |=> (act_o & $past(cpu_sel_i)) == $past(cpu_sel_i));

    // R9
    model_ack_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i && model_o && !wr_hit_i && (line_i & ~lvl_o) == '0 |=> pend_o == '0);

    // R10
    deact_only_one_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deact_i && !ack_i && !wr_hit_i
        |=> (act_o & $past(cpu_sel_i)) == '0
            && (act_o & ~$past(cpu_sel_i)) == ($past(act_o) & ~$past(cpu_sel_i)));

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu_chk
        // R6
        edge_rise_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
            edge_o && line_i[c] && !lvl_o[c] && !ack_i && !wr_hit_i |=> pend_o[c]);
        if (!LEGACY) begin : g_live_chk
            // R4
            level_high_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !edge_o && line_i[c] && !wr_hit_i |=> status_o[c]);
        end
    end

endmodule

// File: rtl/irq_prio_store.sv
module irq_prio_store #(
    parameter int NIRQ  = 64,
    parameter int NCPU  = 8,
    parameter int NBANK = 32,
    parameter int PW    = 8,
    parameter int IW    = $clog2(NIRQ),
    parameter int CW    = $clog2(NCPU)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [IW-1:0]   wr_irq_i,
    input  logic [NCPU-1:0] wr_mask_i,
    input  logic [PW-1:0]   wr_prio_i,
    input  logic [IW-1:0]   rd_irq_i,
    input  logic [CW-1:0]   rd_cpu_i,
    output logic [PW-1:0]   rd_prio_o
);

    localparam int NSHR = NIRQ - NBANK;
    localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int SW   = (NSHR > 1) ? $clog2(NSHR) : 1;
    localparam logic [IW-1:0] NBANK_I = IW'(NBANK);

    typedef struct packed {
        logic [NBANK-1:0][NCPU-1:0][PW-1:0] bank;
        logic [NSHR-1:0][PW-1:0]            shr;
    } prio_t;

    prio_t prio_d, prio_q;
    logic  wr_banked, rd_banked;

    assign wr_banked = wr_irq_i < NBANK_I;
    assign rd_banked = rd_irq_i < NBANK_I;

    always_comb begin
        prio_d = prio_q;
        if (wr_en_i) begin
            if (wr_banked) begin
                for (int c = 0; c < NCPU; c++) begin
                    if (wr_mask_i[c]) begin
                        prio_d.bank[wr_irq_i[BW-1:0]][c] = wr_prio_i;
                    end
                end
            end else begin
                prio_d.shr[SW'(wr_irq_i - NBANK_I)] = wr_prio_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else begin
            prio_q <= prio_d;
        end
    end

    assign rd_prio_o = rd_banked ? prio_q.bank[rd_irq_i[BW-1:0]][rd_cpu_i]
                                 : prio_q.shr[SW'(rd_irq_i - NBANK_I)];

    for (genvar c = 0; c < NCPU; c++) begin : g_bank_chk
        // R11
        unmasked_copy_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_i && wr_banked && !wr_mask_i[c]
            |=> prio_q.bank[$past(wr_irq_i[BW-1:0])][c]
                == $past(prio_q.bank[wr_irq_i[BW-1:0]][c]));
    end

endmodule

// File: rtl/irq_state_array.sv
module irq_state_array
    import irqs_pkg::*;
#(
    parameter int NUM_IRQ    = 64,
    parameter int NUM_CPU    = 8,
    parameter int NUM_BANKED = 32,
    parameter int PRIO_W     = 8,
    parameter bit LEGACY     = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_IRQ*NUM_CPU-1:0] irq_line_i,
    input  logic                       sw_wr_i,
    input  logic [3:0]                 sw_op_i,
    input  logic [$clog2(NUM_IRQ)-1:0] sw_irq_i,
    input  logic [NUM_CPU-1:0]         sw_cpu_mask_i,
    input  logic [PRIO_W-1:0]          sw_data_i,
    input  logic [$clog2(NUM_IRQ)-1:0] rd_irq_i,
    output logic [NUM_CPU-1:0]         rd_enable_o,
    output logic [NUM_CPU-1:0]         rd_pend_o,
    output logic [NUM_CPU-1:0]         rd_active_o,
    output logic [NUM_CPU-1:0]         rd_level_o,
    output logic [NUM_CPU-1:0]         rd_group_o,
    output logic                       rd_edge_o,
    output logic                       rd_model_o,
    input  logic [$clog2(NUM_IRQ)-1:0] q_irq_i,
    input  logic [$clog2(NUM_CPU)-1:0] q_cpu_i,
    output logic                       q_pending_o,
    output logic [PRIO_W-1:0]          q_prio_o,
    input  logic                       ack_i,
    input  logic                       deact_i,
    input  logic [$clog2(NUM_IRQ)-1:0] cmd_irq_i,
    input  logic [$clog2(NUM_CPU)-1:0] cmd_cpu_i
);

    localparam int IW = $clog2(NUM_IRQ);
    localparam int CW = $clog2(NUM_CPU);

    sw_op_e                           sw_op;
    logic [NUM_CPU-1:0]               cmd_oh;
    logic                             prio_wr;
    logic [NUM_IRQ-1:0][NUM_CPU-1:0]  en_a, pend_a, act_a, lvl_a, grp_a, stat_a;
    logic [NUM_IRQ-1:0]               edge_a, model_a;

    assign sw_op   = sw_op_e'(sw_op_i);
    assign cmd_oh  = NUM_CPU'(1) << cmd_cpu_i;
    assign prio_wr = sw_wr_i && (sw_op == OP_PRIO);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        logic wr_hit, ack_hit, deact_hit;
        assign wr_hit    = sw_wr_i && (sw_irq_i == IW'(i));
        assign ack_hit   = ack_i && (cmd_irq_i == IW'(i));
        assign deact_hit = deact_i && (cmd_irq_i == IW'(i));

        irq_slot #(
            .NCPU   (NUM_CPU),
            .LEGACY (LEGACY)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_i    (irq_line_i[i*NUM_CPU +: NUM_CPU]),
            .wr_hit_i  (wr_hit),
            .wr_op_i   (sw_op),
            .wr_mask_i (sw_cpu_mask_i),
            .wr_bit_i  (sw_data_i[0]),
            .ack_i     (ack_hit),
            .deact_i   (deact_hit),
            .cpu_sel_i (cmd_oh),
            .en_o      (en_a[i]),
            .pend_o    (pend_a[i]),
            .act_o     (act_a[i]),
            .lvl_o     (lvl_a[i]),
            .grp_o     (grp_a[i]),
            .status_o  (stat_a[i]),
            .edge_o    (edge_a[i]),
            .model_o   (model_a[i])
        );
    end

    irq_prio_store #(
        .NIRQ  (NUM_IRQ),
        .NCPU  (NUM_CPU),
        .NBANK (NUM_BANKED),
        .PW    (PRIO_W),
        .IW    (IW),
        .CW    (CW)
    ) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (prio_wr),
        .wr_irq_i  (sw_irq_i),
        .wr_mask_i (sw_cpu_mask_i),
        .wr_prio_i (sw_data_i),
        .rd_irq_i  (q_irq_i),
        .rd_cpu_i  (q_cpu_i),
        .rd_prio_o (q_prio_o)
    );

    assign rd_enable_o = en_a[rd_irq_i];
    assign rd_pend_o   = pend_a[rd_irq_i];
    assign rd_active_o = act_a[rd_irq_i];
    assign rd_level_o  = lvl_a[rd_irq_i];
    assign rd_group_o  = grp_a[rd_irq_i];
    assign rd_edge_o   = edge_a[rd_irq_i];
    assign rd_model_o  = model_a[rd_irq_i];
    assign q_pending_o = stat_a[q_irq_i][q_cpu_i];

endmodule

// File: tb/tb_irq_state_array.sv
module tb_irq_state_array;

    localparam int NI = 8;
    localparam int NC = 2;
    localparam int NB = 4;
    localparam int PW = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NI*NC-1:0] lines;
    logic           sw_wr;
    logic [3:0]     sw_op;
    logic [2:0]     sw_irq;
    logic [NC-1:0]  sw_mask;
    logic [PW-1:0]  sw_data;
    logic [2:0]     rd_irq;
    logic [2:0]     q_irq;
    logic           q_cpu;
    logic           ack, deact;
    logic [2:0]     cmd_irq;
    logic           cmd_cpu;

    logic [NC-1:0]  rd_en, rd_pend, rd_act, rd_lvl, rd_grp;
    logic           rd_edge, rd_model, q_pend;
    logic [PW-1:0]  q_prio;
    logic [NC-1:0]  l_en, l_pend, l_act, l_lvl, l_grp;
    logic           l_edge, l_model, l_q_pend;
    logic [PW-1:0]  l_q_prio;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_state_array #(.NUM_IRQ(NI), .NUM_CPU(NC), .NUM_BANKED(NB), .PRIO_W(PW), .LEGACY(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .irq_line_i(lines),
        .sw_wr_i(sw_wr), .sw_op_i(sw_op), .sw_irq_i(sw_irq), .sw_cpu_mask_i(sw_mask), .sw_data_i(sw_data),
        .rd_irq_i(rd_irq), .rd_enable_o(rd_en), .rd_pend_o(rd_pend), .rd_active_o(rd_act),
        .rd_level_o(rd_lvl), .rd_group_o(rd_grp), .rd_edge_o(rd_edge), .rd_model_o(rd_model),
        .q_irq_i(q_irq), .q_cpu_i(q_cpu), .q_pending_o(q_pend), .q_prio_o(q_prio),
        .ack_i(ack), .deact_i(deact), .cmd_irq_i(cmd_irq), .cmd_cpu_i(cmd_cpu)
    );

    irq_state_array #(.NUM_IRQ(NI), .NUM_CPU(NC), .NUM_BANKED(NB), .PRIO_W(PW), .LEGACY(1'b1)) dut_leg (
        .clk(clk), .rst_n(rst_n), .irq_line_i(lines),
        .sw_wr_i(sw_wr), .sw_op_i(sw_op), .sw_irq_i(sw_irq), .sw_cpu_mask_i(sw_mask), .sw_data_i(sw_data),
        .rd_irq_i(rd_irq), .rd_enable_o(l_en), .rd_pend_o(l_pend), .rd_active_o(l_act),
        .rd_level_o(l_lvl), .rd_group_o(l_grp), .rd_edge_o(l_edge), .rd_model_o(l_model),
        .q_irq_i(q_irq), .q_cpu_i(q_cpu), .q_pending_o(l_q_pend), .q_prio_o(l_q_prio),
        .ack_i(ack), .deact_i(deact), .cmd_irq_i(cmd_irq), .cmd_cpu_i(cmd_cpu)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic sw(input int op, input int irq, input int mask, input int data);
        @(negedge clk);
        sw_wr   = 1'b1;
        sw_op   = 4'(op);
        sw_irq  = 3'(irq);
        sw_mask = NC'(mask);
        sw_data = PW'(data);
        @(negedge clk);
        sw_wr   = 1'b0;
    endtask

    task automatic cmd(input bit a, input bit d, input int irq, input int cpu);
        @(negedge clk);
        ack     = a;
        deact   = d;
        cmd_irq = 3'(irq);
        cmd_cpu = cpu[0];
        @(negedge clk);
        ack     = 1'b0;
        deact   = 1'b0;
    endtask

    task automatic set_line(input int irq, input int cpu, input bit v);
        @(negedge clk);
        lines[irq*NC+cpu] = v;
        @(negedge clk);
    endtask

    // field: 0 enable, 1 latched pending, 2 active, 3 group
    task automatic rdf(input int irq, input int field, output int v);
        rd_irq = 3'(irq);
        #1;
        case (field)
            0: v = int'(rd_en);
            1: v = int'(rd_pend);
            2: v = int'(rd_act);
            default: v = int'(rd_grp);
        endcase
    endtask

    task automatic qry(input int irq, input int cpu, output int p, output int lp, output int pr);
        q_irq = 3'(irq);
        q_cpu = cpu[0];
        #1;
        p  = int'(q_pend);
        lp = int'(l_q_pend);
        pr = int'(q_prio);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, p, lp, pr;
        rst_n = 1'b0; lines = '0; sw_wr = 1'b0; sw_op = '0; sw_irq = '0; sw_mask = '0;
        sw_data = '0; rd_irq = '0; q_irq = '0; q_cpu = 1'b0; ack = 1'b0; deact = 1'b0;
        cmd_irq = '0; cmd_cpu = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < NI; i++) begin
            for (int f = 0; f < 4; f++) begin
                rdf(i, f, v);
                chk("R1 mask", v, 0);
            end
            chk("R1 edge", int'(rd_edge), 0);
            chk("R1 model", int'(rd_model), 0);
            for (int c = 0; c < NC; c++) begin
                qry(i, c, p, lp, pr);
                chk("R1 prio", pr, 0);
            end
        end

        // R2 set/clear sweep over field, interrupt, mask
        for (int f = 0; f < 4; f++) begin
            for (int i = 0; i < NI; i++) begin
                for (int m = 0; m < 4; m++) begin
                    sw(f*2+1, i, 3, 0);
                    sw(f*2, i, m, 0);
                    rdf(i, f, v);
                    chk("R2 set", v, m);
                    sw(f*2+1, i, 1, 0);
                    rdf(i, f, v);
                    chk("R2 clear", v, m & 2);
                    sw(f*2+1, i, 3, 0);
                end
            end
        end

        // R3 reserved op codes leave state alone
        sw(0, 2, 3, 0);
        sw(6, 2, 1, 0);
        for (int op = 11; op < 16; op++) begin
            sw(op, 2, 3, 15);
            rdf(2, 0, v); chk("R3 enable", v, 3);
            rdf(2, 3, v); chk("R3 group", v, 1);
            rdf(2, 1, v); chk("R3 pending", v, 0);
            rdf(2, 2, v); chk("R3 active", v, 0);
            chk("R3 edge", int'(rd_edge), 0);
            chk("R3 model", int'(rd_model), 0);
            qry(2, 0, p, lp, pr); chk("R3 prio", pr, 0);
        end
        sw(1, 2, 3, 0);
        sw(7, 2, 3, 0);

        // R4 / R7 level line, normal versus legacy
        set_line(5, 1, 1'b1);
        qry(5, 1, p, lp, pr);
        chk("R4 level high pending", p, 1);
        chk("R7 legacy latched on rise", lp, 1);
        qry(5, 0, p, lp, pr);
        chk("R4 other cpu idle", p, 0);
        rdf(5, 1, v);
        chk("R4 no latch", v, 0);
        rdf(5, 3, v);
        chk("R4 level readback", int'(rd_lvl), 2);
        set_line(5, 1, 1'b0);
        qry(5, 1, p, lp, pr);
        chk("R4 level low not pending", p, 0);
        chk("R7 legacy stays pending", lp, 1);
        sw(3, 5, 3, 0);
        qry(5, 1, p, lp, pr);
        chk("R7 legacy cleared", lp, 0);

        // R5 software pending plus live level
        sw(2, 4, 1, 0);
        qry(4, 0, p, lp, pr);
        chk("R5 sw pending", p, 1);
        set_line(4, 0, 1'b1);
        sw(3, 4, 1, 0);
        qry(4, 0, p, lp, pr);
        chk("R5 line holds pending", p, 1);
        chk("R7 legacy no level term", lp, 0);
        set_line(4, 0, 1'b0);
        qry(4, 0, p, lp, pr);
        chk("R5 released", p, 0);

        // R6 edge trigger
        sw(8, 6, 0, 1);
        rdf(6, 0, v);
        chk("R6 edge mode", int'(rd_edge), 1);
        set_line(6, 0, 1'b1);
        rdf(6, 1, v);
        chk("R6 rise latches", v, 1);
        qry(6, 1, p, lp, pr);
        chk("R6 other cpu", p, 0);
        set_line(6, 0, 1'b0);
        qry(6, 0, p, lp, pr);
        chk("R6 held after fall", p, 1);
        sw(3, 6, 1, 0);
        set_line(6, 0, 1'b1);
        sw(3, 6, 1, 0);
        qry(6, 0, p, lp, pr);
        chk("R6 no level term", p, 0);
        set_line(6, 0, 1'b0);

        // R8 acknowledge, per-CPU model
        sw(2, 1, 3, 0);
        cmd(1'b1, 1'b0, 1, 1);
        rdf(1, 1, v); chk("R8 pend one cpu", v, 1);
        rdf(1, 2, v); chk("R8 active set", v, 2);

        // R9 acknowledge, all-CPU model
        sw(2, 3, 3, 0);
        sw(9, 3, 0, 1);
        rdf(3, 0, v); chk("R9 model bit", int'(rd_model), 1);
        cmd(1'b1, 1'b0, 3, 0);
        rdf(3, 1, v); chk("R9 pend all cleared", v, 0);
        rdf(3, 2, v); chk("R9 active", v, 1);

        // R10 deactivate
        sw(4, 1, 1, 0);
        rdf(1, 2, v); chk("R10 both active", v, 3);
        cmd(1'b0, 1'b1, 1, 1);
        rdf(1, 2, v); chk("R10 cpu1 only", v, 1);
        cmd(1'b0, 1'b1, 1, 0);
        rdf(1, 2, v); chk("R10 cpu0", v, 0);

        // R11 banked versus shared priority
        for (int i = 0; i < NI; i++) begin
            sw(10, i, 1, (i*3+1) & 15);
            sw(10, i, 2, (i*5+2) & 15);
        end
        for (int i = 0; i < NI; i++) begin
            qry(i, 0, p, lp, pr);
            chk("R11 cpu0", pr, (i < NB) ? ((i*3+1) & 15) : ((i*5+2) & 15));
            qry(i, 1, p, lp, pr);
            chk("R11 cpu1", pr, (i*5+2) & 15);
        end
        sw(10, 0, 0, 9);
        qry(0, 0, p, lp, pr); chk("R11 empty mask cpu0", pr, 1);
        qry(0, 1, p, lp, pr); chk("R11 empty mask cpu1", pr, 2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule